// File: doc/BRIEF.md
# Snooping Write-Back Data Cache Coherence Controller

This block is the coherence engine of a small direct-mapped write-back data cache. Each line is in one of three states: modified, exclusive or invalid. There is no shared state. Processor loads and stores arrive on a request port. Each request carries four page attributes: write-through, caching-inhibited, coherence-required and guarded. These attributes decide whether the access uses the cache, whether stores go straight to memory, and how the resulting bus transaction is marked.

A second port carries addresses that other bus masters put on the bus. Each such address is compared with the tag store. On a hit the block raises a retry response one cycle later. A hit on an exclusive line drops that line. A hit on a modified line queues a push of the line's data to memory, and the line goes invalid when the push completes. A simple request/acknowledge bus master carries line fills, victim write-backs, pushes and single-beat uncached or write-through transfers.

Top module: `mei_dcache`

## Requirements
- R1: After reset no bus request, no response and no retry are asserted, every line is invalid, and a request is accepted at once.
- R2: A cacheable load miss issues one line read (bus_op code 0) at the line address and returns the bus data. The line is then exclusive. A later load hit returns the cached data with no bus transaction.
- R3: A cacheable store hit on an exclusive line without write-through makes the line modified and issues no bus transaction.
- R4: snp_retry is high in the cycle after a snoop address is presented exactly when that address matches the tag of a valid line at its index. It is low in every other cycle.
- R5: A snoop hit on an exclusive line invalidates it without any bus transaction.
- R6: A snoop hit on a modified line issues one line write (bus_op code 1) of that line's data to the snooped address, with bus_global low. The line is invalid once the write is acknowledged.
- R7: While a push is outstanding, further snoops to the pushed line are retried, no second push starts, and no processor request is accepted.
- R8: A caching-inhibited access issues a single-beat read (code 2) or write (code 3) at the request address. It allocates nothing, so a later snoop to it is not retried. A bus request and its address and operation are held until acknowledged.
- R9: A write-through store always issues a single-beat write (code 3). On a hit it updates the cached data and leaves an exclusive line exclusive. On a miss it allocates nothing.
- R10: A miss whose victim line is modified first writes the victim back (code 1, victim address), then issues the line read.
- R11: Bus transactions caused by a processor access carry bus_global equal to its coherence-required attribute and bus_guarded equal to its guarded attribute.
- R12: A store miss without write-through fills the line with a line read and leaves it modified, holding the store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Physical word address |
| req_wdata | input | DATA_W | Store data |
| req_wt | input | 1 | Write-through attribute |
| req_ci | input | 1 | Caching-inhibited attribute |
| req_coh | input | 1 | Coherence-required attribute |
| req_grd | input | 1 | Guarded attribute |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data |
| snp_valid | input | 1 | Snoop address present |
| snp_addr | input | ADDR_W | Address referenced by another master |
| snp_retry | output | 1 | Retry response for the previous snoop |
| bus_req | output | 1 | Bus transaction request |
| bus_op | output | 2 | 0 line read, 1 line write, 2 word read, 3 word write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data |
| bus_global | output | 1 | Transaction must be snooped by other caches |
| bus_guarded | output | 1 | Guarded attribute of the access |
| bus_ack | input | 1 | Completes the current transaction |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
The assertions check on every cycle that a retry appears only after a snoop, that a bus request holds its operation and address until acknowledged, and that an outstanding push is stable and blocks processor requests. They also check that a victim write-back is followed directly by the line read, and that a push is a non-global line write. Whether a retry should have fired, which states lines hold after write-through, caching-inhibited and silent-upgrade accesses, and what data a push or fill carries can only be shown by the bench. It does this with a model of line states and memory contents driven through those scenarios.

// File: rtl/mei_pkg.sv
package mei_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_E = 2'd1, LN_M = 2'd2} line_st_t;
  typedef enum logic [1:0] {
    BOP_RD_LINE = 2'd0, BOP_WR_LINE = 2'd1, BOP_RD_WORD = 2'd2, BOP_WR_WORD = 2'd3
  } bus_op_t;
  typedef enum logic [2:0] {F_IDLE, F_WB, F_FILL, F_SGL, F_PUSH} fsm_t;
endpackage

// File: rtl/mei_line_store.sv
module mei_line_store
  import mei_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_state,
  output logic [TAG_W-1:0]  b_tag,
  input  logic              w_full,
  input  logic              w_st_only,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_t          w_state,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic              i_en,
  input  logic [IDX_W-1:0]  i_idx
);
  localparam int SETS = 1 << IDX_W;

  line_st_t          st_q  [SETS];
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  // state bits need reset; controller port is written last so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LN_I;
    end else begin
      if (i_en) st_q[i_idx] <= LN_I;
      if (w_full || w_st_only) st_q[w_idx] <= w_state;
    end
  end

  always_ff @(posedge clk) begin
    if (w_full) begin
      tag_q[w_idx] <= w_tag;
      dat_q[w_idx] <= w_data;
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
endmodule

// File: rtl/mei_snoop_unit.sv
module mei_snoop_unit
  import mei_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  b_idx,
  input  line_st_t          b_state,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0] b_tag,
  input  logic              wb_busy,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              push_done,
  output logic              snp_retry,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx,
  output logic              push_pend,
  output logic [IDX_W-1:0]  push_idx,
  output logic [ADDR_W-1:0] push_addr
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0] s_tag;
  logic             hit, start;

  assign b_idx   = snp_addr[OFF_W +: IDX_W];
  assign s_tag   = snp_addr[ADDR_W-1 -: TAG_W];
  assign hit     = snp_valid && (b_state != LN_I) && (b_tag == s_tag);
  assign inv_en  = hit && (b_state == LN_E);
  assign inv_idx = b_idx;
  // only one push in flight; a line being cast out is not pushed twice
  assign start   = hit && (b_state == LN_M) && !push_pend &&
                   !(wb_busy && (wb_idx == b_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_retry <= 1'b0;
      push_pend <= 1'b0;
      push_idx  <= '0;
      push_addr <= '0;
    end else begin
      snp_retry <= hit;
      if (push_done) begin
        push_pend <= 1'b0;
      end else if (start) begin
        push_pend <= 1'b1;
        push_idx  <= b_idx;
        push_addr <= snp_addr;
      end
    end
  end
endmodule

// File: rtl/mei_dcache.sv
module mei_dcache
  import mei_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wt,
  input  logic              req_ci,
  input  logic              req_coh,
  input  logic              req_grd,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_retry,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_global,
  output logic              bus_guarded,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  fsm_t st;
  logic [IDX_W-1:0]  r_idx, q_idx, a_idx, b_idx, inv_idx, push_idx;
  logic [TAG_W-1:0]  r_tag, q_tag, a_tag, b_tag, w_tag;
  logic [DATA_W-1:0] a_data, w_data, q_wdata;
  logic [ADDR_W-1:0] push_addr;
  line_st_t          a_state, b_state, w_state;
  logic q_write, w_full, w_st_only, inv_en, push_pend, push_done;
  logic accept, a_hit, wb_busy, push_busy;

  assign r_idx     = req_addr[OFF_W +: IDX_W];
  assign r_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign req_ready = (st == F_IDLE) && !push_pend && !snp_valid;
  assign accept    = req_valid && req_ready;
  assign a_hit     = (a_state != LN_I) && (a_tag == r_tag);
  assign wb_busy   = (st == F_WB);
  assign push_busy = (st == F_PUSH);
  assign push_done = push_busy && bus_ack;

  always_comb begin
    if (push_busy || (st == F_IDLE && push_pend)) a_idx = push_idx;
    else if (st == F_IDLE)                         a_idx = r_idx;
    else                                           a_idx = q_idx;
  end

  mei_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag),
    .w_full(w_full), .w_st_only(w_st_only), .w_idx(w_idx_c), .w_state(w_state),
    .w_tag(w_tag), .w_data(w_data), .i_en(inv_en), .i_idx(inv_idx)
  );

  mei_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_snoop (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag),
    .wb_busy(wb_busy), .wb_idx(q_idx), .push_done(push_done),
    .snp_retry(snp_retry), .inv_en(inv_en), .inv_idx(inv_idx),
    .push_pend(push_pend), .push_idx(push_idx), .push_addr(push_addr)
  );

  logic [IDX_W-1:0] w_idx_c;

  always_comb begin
    w_full    = 1'b0;
    w_st_only = 1'b0;
    w_idx_c   = q_idx;
    w_state   = LN_I;
    w_tag     = q_tag;
    w_data    = q_wdata;
    unique case (st)
      F_IDLE: if (!push_pend && accept && !req_ci && req_write && a_hit) begin
        w_full  = 1'b1;
        w_idx_c = r_idx;
        w_tag   = r_tag;
        w_data  = req_wdata;
        w_state = req_wt ? a_state : LN_M;
      end
      F_WB:   if (bus_ack) w_st_only = 1'b1;
      F_FILL: if (bus_ack) begin
        w_full  = 1'b1;
        w_data  = q_write ? q_wdata : bus_rdata;
        w_state = q_write ? LN_M : LN_E;
      end
      F_PUSH: if (bus_ack) begin
        w_st_only = 1'b1;
        w_idx_c   = push_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= F_IDLE;
      bus_req     <= 1'b0;
      bus_op      <= BOP_RD_LINE;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_global  <= 1'b0;
      bus_guarded <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      q_idx       <= '0;
      q_tag       <= '0;
      q_wdata     <= '0;
      q_write     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        F_IDLE: begin
          if (push_pend) begin
            bus_req     <= 1'b1;
            bus_op      <= BOP_WR_LINE;
            bus_addr    <= push_addr;
            bus_wdata   <= a_data;
            bus_global  <= 1'b0;
            bus_guarded <= 1'b0;
            st          <= F_PUSH;
          end else if (accept) begin
            q_idx       <= r_idx;
            q_tag       <= r_tag;
            q_wdata     <= req_wdata;
            q_write     <= req_write;
            bus_global  <= req_coh;
            bus_guarded <= req_grd;
            bus_wdata   <= req_wdata;
            if (req_ci || (req_write && req_wt)) begin
              bus_req  <= 1'b1;
              bus_op   <= req_write ? BOP_WR_WORD : BOP_RD_WORD;
              bus_addr <= req_addr;
              st       <= F_SGL;
            end else if (a_hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= req_write ? req_wdata : a_data;
            end else if (a_state == LN_M) begin
              bus_req   <= 1'b1;
              bus_op    <= BOP_WR_LINE;
              bus_addr  <= {a_tag, r_idx, {OFF_W{1'b0}}};
              bus_wdata <= a_data;
              st        <= F_WB;
            end else begin
              bus_req  <= 1'b1;
              bus_op   <= BOP_RD_LINE;
              bus_addr <= {r_tag, r_idx, {OFF_W{1'b0}}};
              st       <= F_FILL;
            end
          end
        end
        F_WB: if (bus_ack) begin
          bus_op   <= BOP_RD_LINE;
          bus_addr <= {q_tag, q_idx, {OFF_W{1'b0}}};
          st       <= F_FILL;
        end
        F_FILL, F_SGL: if (bus_ack) begin
          bus_req   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= bus_rdata;
          st        <= F_IDLE;
        end
        F_PUSH: if (bus_ack) begin
          bus_req <= 1'b0;
          st      <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mei_dcache_chk.sv
module mei_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              snp_valid,
  input logic              snp_retry,
  input logic              req_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_global,
  input logic              push_pend,
  input logic [IDX_W-1:0]  push_idx,
  input logic              push_done,
  input logic              wb_busy,
  input logic              push_busy
);
  AST_RETRY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_retry |-> $past(snp_valid)); // R4
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_op) && $stable(bus_addr)); // R8
  AST_PUSH_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
    push_pend |-> !req_ready); // R7
  AST_PUSH_STABLE: assert property (@(posedge clk) disable iff (rst)
    push_pend && !push_done |=> push_pend && $stable(push_idx)); // R7
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    wb_busy && bus_ack |=> bus_req && bus_op == 2'd0); // R10
  AST_PUSH_SHAPE: assert property (@(posedge clk) disable iff (rst)
    push_busy && bus_req |-> !bus_global && bus_op == 2'd1); // R6
endmodule

bind mei_dcache mei_dcache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_retry(snp_retry),
  .req_ready(req_ready), .bus_req(bus_req), .bus_ack(bus_ack), .bus_op(bus_op),
  .bus_addr(bus_addr), .bus_global(bus_global), .push_pend(push_pend),
  .push_idx(push_idx), .push_done(push_done), .wb_busy(wb_busy),
  .push_busy(push_busy)
);

// File: tb/tb_mei_dcache.sv
module tb_mei_dcache;
  localparam int LAT = 4;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_wt = 0, req_ci = 0, req_coh = 0, req_grd = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, snp_addr = 0, bus_rdata = 0;
  logic snp_valid = 0, bus_ack = 0;
  logic req_ready, rsp_valid, snp_retry, bus_req, bus_global, bus_guarded;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [1:0] bus_op;

  mei_dcache dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mem [logic [31:0]];
  logic [1:0]  lop[$];
  logic [31:0] laddr[$], ldata[$];
  logic        lglob[$], lgrd[$];
  int mst[4];
  logic [27:0] mtg[4];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  // reference line-state model (0 invalid, 1 exclusive, 2 modified)
  function automatic void model_access(input bit wr, input logic [31:0] a, input bit wt, input bit ci);
    int i = int'(a[3:2]);
    bit hit = mst[i] != 0 && mtg[i] == a[31:4];
    if (ci) return;
    if (wr && wt) return;
    if (hit) begin if (wr) mst[i] = 2; end
    else begin mst[i] = wr ? 2 : 1; mtg[i] = a[31:4]; end
  endfunction

  function automatic bit model_snoop(input logic [31:0] a);
    int i = int'(a[3:2]);
    bit hit = mst[i] != 0 && mtg[i] == a[31:4];
    if (hit && mst[i] == 1) mst[i] = 0;
    return hit;
  endfunction

  // bus responder
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 0;
      else if (bus_req) begin
        if (lat == LAT - 1) begin
          lat = 0;
          bus_ack = 1;
          bus_rdata = memrd(bus_addr);
          lop.push_back(bus_op); laddr.push_back(bus_addr); ldata.push_back(bus_wdata);
          lglob.push_back(bus_global); lgrd.push_back(bus_guarded);
          if (bus_op[0]) mem[bus_addr] = bus_wdata;
        end else lat++;
      end else lat = 0;
    end
  end

  // every cycle: no retry unless a snoop was presented on the previous edge (R4)
  logic snp_seen = 0;
  always @(posedge clk) snp_seen <= snp_valid;
  always begin
    @(negedge clk); #1;
    if (!rst && !snp_seen) chk(snp_retry === 1'b0, "R4 idle retry", {31'd0, snp_retry}, 0);
  end

  task automatic clr_log();
    lop.delete(); laddr.delete(); ldata.delete(); lglob.delete(); lgrd.delete();
  endtask

  task automatic cpu(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                     input bit wt, input bit ci, input bit coh, input bit grd,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    req_wt = wt; req_ci = ci; req_coh = coh; req_grd = grd;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    model_access(wr, a, wt, ci);
  endtask

  task automatic snoop(input logic [31:0] a, input string rq);
    bit e = model_snoop(a);
    @(negedge clk); snp_valid = 1; snp_addr = a;
    @(negedge clk); snp_valid = 0; #1;
    chk(snp_retry === e, rq, {31'd0, snp_retry}, {31'd0, e});
  endtask

  task automatic settle();
    repeat (3 * LAT + 6) @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  localparam logic [31:0] A = 32'h0000_1004, B = 32'h0000_100C, C = 32'h8000_0000;
  localparam logic [31:0] D = 32'h0000_2008, E2 = 32'h0000_3008, F = 32'h0000_4000;

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtg[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(bus_req === 0, "R1 bus_req", {31'd0, bus_req}, 0);
    chk(rsp_valid === 0, "R1 rsp_valid", {31'd0, rsp_valid}, 0);
    chk(snp_retry === 0, "R1 snp_retry", {31'd0, snp_retry}, 0);
    chk(req_ready === 1, "R1 req_ready", {31'd0, req_ready}, 1);
    snoop(A, "R1 all lines invalid");

    // load miss then hit
    clr_log();
    cpu(0, A, 0, 0, 0, 1, 0, rd);
    chk(rd === memrd(A), "R2 fill data", rd, memrd(A));
    chk(lop.size() == 1 && lop[0] == 2'd0 && laddr[0] == A, "R2 line read", {30'd0, lop[0]}, 0);
    chk(lglob[0] === 1, "R11 global from coh=1", {31'd0, lglob[0]}, 1);
    clr_log();
    cpu(0, A, 0, 0, 0, 1, 0, rd);
    chk(rd === memrd(A) && lop.size() == 0, "R2 hit no bus", lop.size(), 0);

    // snoop of exclusive line
    clr_log();
    snoop(A, "R5 retry on exclusive");
    settle();
    chk(lop.size() == 0, "R5 no bus on invalidate", lop.size(), 0);
    snoop(A, "R5 line gone");

    // silent upgrade, then push
    clr_log();
    cpu(0, A, 0, 0, 0, 0, 0, rd);
    chk(lglob[0] === 0, "R11 global from coh=0", {31'd0, lglob[0]}, 0);
    clr_log();
    cpu(1, A, 32'h1111_1111, 0, 0, 1, 0, rd);
    settle();
    chk(lop.size() == 0, "R3 silent upgrade", lop.size(), 0);
    snoop(A, "R6 retry on modified");
    snoop(A, "R7 retry during push");
    settle();
    chk(lop.size() == 1, "R7 single push", lop.size(), 1);
    chk(lop[0] == 2'd1 && laddr[0] == A, "R6 push op/addr", laddr[0], A);
    chk(ldata[0] === 32'h1111_1111, "R6 push data", ldata[0], 32'h1111_1111);
    chk(lglob[0] === 0, "R6 push not global", {31'd0, lglob[0]}, 0);
    mst[1] = 0;
    snoop(A, "R6 invalid after push");
    cpu(0, A, 0, 0, 0, 1, 0, rd);
    chk(rd === 32'h1111_1111, "R6 memory holds pushed data", rd, 32'h1111_1111);

    // write-through
    cpu(0, B, 0, 0, 0, 1, 0, rd);
    clr_log();
    cpu(1, B, 32'h2222_2222, 1, 0, 1, 0, rd);
    chk(lop.size() == 1 && lop[0] == 2'd3 && laddr[0] == B, "R9 single write", lop.size(), 1);
    chk(ldata[0] === 32'h2222_2222, "R9 write data", ldata[0], 32'h2222_2222);
    clr_log();
    cpu(0, B, 0, 0, 0, 1, 0, rd);
    chk(rd === 32'h2222_2222 && lop.size() == 0, "R9 hit data updated", rd, 32'h2222_2222);
    snoop(B, "R9 line still cached");
    settle();
    chk(lop.size() == 0, "R9 line stayed exclusive (no push)", lop.size(), 0);

    // caching-inhibited
    clr_log();
    cpu(0, C, 0, 0, 1, 1, 1, rd);
    chk(lop.size() == 1 && lop[0] == 2'd2 && laddr[0] == C, "R8 word read", {30'd0, lop[0]}, 2);
    chk(rd === memrd(C), "R8 read data", rd, memrd(C));
    chk(lgrd[0] === 1, "R11 guarded passed", {31'd0, lgrd[0]}, 1);
    clr_log();
    cpu(1, C, 32'h3333_3333, 0, 1, 0, 0, rd);
    chk(lop.size() == 1 && lop[0] == 2'd3 && lgrd[0] == 0, "R8 word write", {30'd0, lop[0]}, 3);
    snoop(C, "R8 no allocation");

    // store miss allocate, then victim write-back
    clr_log();
    cpu(1, D, 32'h4444_4444, 0, 0, 1, 0, rd);
    chk(lop.size() == 1 && lop[0] == 2'd0 && laddr[0] == D, "R12 fill for store", lop.size(), 1);
    clr_log();
    cpu(0, E2, 0, 0, 0, 1, 0, rd);
    chk(lop.size() == 2, "R10 two transactions", lop.size(), 2);
    chk(lop[0] == 2'd1 && laddr[0] == D && ldata[0] == 32'h4444_4444, "R10 victim first", laddr[0], D);
    chk(lop[1] == 2'd0 && laddr[1] == E2, "R10 fill second", laddr[1], E2);
    chk(rd === memrd(E2), "R10 fill data", rd, memrd(E2));
    chk(memrd(D) === 32'h4444_4444, "R12 line held store data", memrd(D), 32'h4444_4444);

    // write-through miss
    clr_log();
    cpu(1, F, 32'h5555_5555, 1, 0, 1, 0, rd);
    chk(lop.size() == 1 && lop[0] == 2'd3, "R9 miss single write", lop.size(), 1);
    snoop(F, "R9 miss no allocation");
    snoop(32'h0000_9990, "R4 unrelated address");

    settle();
    done = 1;
    report();
  end
endmodule